// File: doc/BRIEF.md
# Pipelined Late-Write SRAM Controller

This block sits between a user request port and a synchronous SRAM whose data bus carries data a fixed number of cycles after the command. One request is accepted per cycle, either a read or a write. The command and address go out on the memory pins in the next cycle. Write data is held back and driven onto the shared bus exactly `LATENCY` cycles later. Read data is sampled from the bus in that same slot. Because the data phase always trails its own command by the same distance, reads and writes can follow each other in any order with no dead cycle on the bus, and no two drivers ever overlap.

`LATENCY` is 2 for a pipelined memory and 1 for a flow-through memory. A read request can ask for up to 2^`BURST_W`−1 extra words. The controller then issues those reads at consecutive addresses, one per cycle, and holds off new requests until the burst is out. A clock enable freezes the whole controller and the memory together. A synchronous active-high reset empties every pipeline stage.

Top module: `pipe_sram_ctrl`

## Requirements
- R1: One cycle after `rst` is sampled high, `mem_sel`, `mem_dq_oe` and `rd_valid` are 0. With `clk_en` high, `req_ready` is then 1.
- R2: A request is accepted at a rising edge where `req_valid` and `req_ready` are both 1. The accepted command appears on `mem_sel`=1, `mem_wr` (1 = write, 0 = read) and `mem_addr` in the following cycle.
- R3: For a write presented in cycle c, `mem_dq_oe` is 1 and `mem_dq_out` equals its data in cycle c+`LATENCY`. `mem_dq_oe` is 0 in every slot that does not belong to a write.
- R4: For a read presented in cycle c, the bus is sampled at the end of cycle c+`LATENCY`. `rd_valid` is 1 for one cycle afterwards, with the sampled word on `rd_data`. Words return in the order the reads were issued.
- R5: Reads and writes may be accepted on every cycle in any mix. While accepted commands are pending, `mem_sel` never drops to 0, and the controller never drives the bus in a slot in which the memory drives it.
- R6: A read accepted with `req_burst`=n issues n more reads at addresses +1…+n on the n cycles that follow. `req_ready` is 0 during those n cycles.
- R7: Burst addresses wrap from 2^`ADDR_W`−1 to 0.
- R8: At an edge where `clk_en` is 0, no request is accepted, `req_ready` is 0, the memory command pins and the bus drive hold their values, and `rd_valid` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_en | input | 1 | Clock enable shared with the memory |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| req_burst | input | BURST_W | Extra words for a read burst |
| req_ready | output | 1 | Request can be accepted this cycle |
| rd_valid | output | 1 | Read word returned |
| rd_data | output | DATA_W | Returned read word |
| mem_sel | output | 1 | Command valid on memory pins |
| mem_wr | output | 1 | Command is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven toward memory |
| mem_dq_oe | output | 1 | Bus output enable |
| mem_dq_in | input | DATA_W | Data received from the bus |

## Verification
The bench builds the controller with `ADDR_W`=6, `DATA_W`=16, `BURST_W`=2 and `LATENCY`=2. This makes a 64-word memory small enough to write and read back in full, and lets every burst length from 0 to 3 start at the top addresses, where the wrap occurs. With a two-stage data pipeline, a read can follow a write to the same address on the very next cycle, so the in-flight forwarding and the alternation with no gap are both reachable. A long pseudo-random phase mixes stalls, rejected requests during bursts and a reset taken while reads are in flight.

// File: rtl/psram_pkg.sv
package psram_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } bus_op_e;

endpackage

// File: rtl/psram_issue.sv
// Request acceptance and burst address sequencing; owns the memory command pins.
module psram_issue
    import psram_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 36,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BURST_W-1:0] req_burst,
    output logic              req_ready,
    output bus_op_e           cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata
);

    typedef struct packed {
        bus_op_e            op;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  wdata;
        logic [BURST_W-1:0] left;
        logic [ADDR_W-1:0]  next_addr;
    } issue_t;

    issue_t st_d, st_q;

    assign req_ready = clk_en && (st_q.left == '0);

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            st_d.op = OP_NONE;
            if (st_q.left != '0) begin
                st_d.op        = OP_RD;
                st_d.addr      = st_q.next_addr;
                st_d.next_addr = st_q.next_addr + ADDR_W'(1);
                st_d.left      = st_q.left - BURST_W'(1);
            end else if (req_valid) begin
                st_d.op        = req_write ? OP_WR : OP_RD;
                st_d.addr      = req_addr;
                st_d.wdata     = req_wdata;
                st_d.next_addr = req_addr + ADDR_W'(1);
                st_d.left      = req_write ? '0 : req_burst;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cmd_op    = st_q.op;
    assign cmd_addr  = st_q.addr;
    assign cmd_wdata = st_q.wdata;

    // R2: an accepted request is on the pins in the next cycle
    a_r2_accept_presents: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (cmd_op != OP_NONE && cmd_addr == $past(req_addr)));

    // R6 / R7: burst words step the address by one, wrapping at the top
    a_r6_burst_step: assert property (@(posedge clk) disable iff (rst)
        (clk_en && st_q.left != '0) |=> (cmd_op == OP_RD && cmd_addr == $past(cmd_addr) + ADDR_W'(1)));

    // R8: a disabled edge leaves the command pins untouched
    a_r8_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(cmd_op) && $stable(cmd_addr)));

endmodule

// File: rtl/psram_pipe.sv
// Delay line from command slot to data slot; drives the bus in write slots only.
module psram_pipe
    import psram_pkg::*;
#(
    parameter int DATA_W  = 36,
    parameter int LATENCY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  bus_op_e           cmd_op,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_out,
    output logic              slot_rd
);

    typedef struct packed {
        bus_op_e           op;
        logic [DATA_W-1:0] data;
    } stage_t;

    stage_t                  fresh;
    stage_t [LATENCY-1:0]    stg_d, stg_q;

    always_comb begin
        fresh.op   = cmd_op;
        fresh.data = (cmd_op == OP_WR) ? cmd_wdata : '0;
    end

    if (LATENCY == 1) begin : g_flow
        always_comb begin
            stg_d[0] = clk_en ? fresh : stg_q[0];
        end
    end else begin : g_piped
        always_comb begin
            stg_d = clk_en ? {stg_q[LATENCY-2:0], fresh} : stg_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dq_oe   = (stg_q[LATENCY-1].op == OP_WR);
    assign dq_out  = stg_q[LATENCY-1].data;
    assign slot_rd = (stg_q[LATENCY-1].op == OP_RD);

    // R8: bus drive is frozen across a disabled edge
    a_r8_bus_hold: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(dq_oe) && $stable(dq_out)));

endmodule

// File: rtl/psram_rdret.sv
// Samples the bus in read slots and presents one strobe per word.
module psram_rdret #(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clk_en,
    input  logic              slot_rd,
    input  logic [DATA_W-1:0] bus_in,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } ret_t;

    ret_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = clk_en && slot_rd;
        if (clk_en && slot_rd) begin
            st_d.data = bus_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.valid;
    assign rd_data  = st_q.data;

    // R4 / R8: a returned word always follows an enabled edge
    a_r4_strobe_after_enable: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> $past(clk_en));

    // R4: returned data holds between strobes
    a_r4_data_holds: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> $stable(rd_data));

endmodule

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
    import psram_pkg::*;
#(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 36,
    parameter int BURST_W = 2,
    parameter int LATENCY = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clk_en,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [BURST_W-1:0] req_burst,
    output logic               req_ready,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               mem_sel,
    output logic               mem_wr,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]  mem_dq_out,
    output logic               mem_dq_oe,
    input  logic [DATA_W-1:0]  mem_dq_in
);

    bus_op_e           cmd_op;
    logic [DATA_W-1:0] cmd_wdata;
    logic              slot_rd;

    psram_issue #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .BURST_W (BURST_W)
    ) u_issue (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_burst (req_burst),
        .req_ready (req_ready),
        .cmd_op    (cmd_op),
        .cmd_addr  (mem_addr),
        .cmd_wdata (cmd_wdata)
    );

    psram_pipe #(
        .DATA_W  (DATA_W),
        .LATENCY (LATENCY)
    ) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .clk_en    (clk_en),
        .cmd_op    (cmd_op),
        .cmd_wdata (cmd_wdata),
        .dq_oe     (mem_dq_oe),
        .dq_out    (mem_dq_out),
        .slot_rd   (slot_rd)
    );

    psram_rdret #(
        .DATA_W (DATA_W)
    ) u_rdret (
        .clk      (clk),
        .rst      (rst),
        .clk_en   (clk_en),
        .slot_rd  (slot_rd),
        .bus_in   (mem_dq_in),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    assign mem_sel = (cmd_op != OP_NONE);
    assign mem_wr  = (cmd_op == OP_WR);

    // R1: reset leaves the memory side quiet
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!mem_sel && !mem_dq_oe && !rd_valid));

endmodule

// File: tb/pipe_sram_ctrl_bench.sv
module pipe_sram_ctrl_bench;

    localparam int AW    = 6;
    localparam int DW    = 16;
    localparam int BW    = 2;
    localparam int LAT   = 2;
    localparam int DEPTH = 1 << AW;
    localparam int QN    = 8192;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clk_en = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [BW-1:0] req_burst = '0;
    logic          req_ready, rd_valid, mem_sel, mem_wr, mem_dq_oe;
    logic [DW-1:0] rd_data, mem_dq_out, mem_dq_in;
    logic [AW-1:0] mem_addr;

    always #5 clk = ~clk;

    pipe_sram_ctrl #(
        .ADDR_W (AW), .DATA_W (DW), .BURST_W (BW), .LATENCY (LAT)
    ) u_pipe_sram_ctrl (
        .clk (clk), .rst (rst), .clk_en (clk_en),
        .req_valid (req_valid), .req_write (req_write), .req_addr (req_addr),
        .req_wdata (req_wdata), .req_burst (req_burst), .req_ready (req_ready),
        .rd_valid (rd_valid), .rd_data (rd_data),
        .mem_sel (mem_sel), .mem_wr (mem_wr), .mem_addr (mem_addr),
        .mem_dq_out (mem_dq_out), .mem_dq_oe (mem_dq_oe), .mem_dq_in (mem_dq_in)
    );

    // ---------------- behavioural late-write SRAM ----------------
    logic [DW-1:0] smem [DEPTH];
    int            s_op [LAT];
    logic [AW-1:0] s_ad [LAT];
    logic          sram_drv = 1'b0;
    logic [DW-1:0] sram_dq = '0;
    int            model_err = 0;

    assign mem_dq_in = sram_drv ? sram_dq : '0;

    always @(posedge clk) begin : model
        int            t_op [LAT];
        logic [AW-1:0] t_ad [LAT];
        if (rst) begin
            for (int k = 0; k < LAT; k++) s_op[k] <= 0;
            sram_drv <= 1'b0;
        end else if (clk_en) begin
            if (s_op[LAT-1] == 2) begin
                if (!mem_dq_oe) model_err = model_err + 1;
                smem[s_ad[LAT-1]] <= mem_dq_out;
            end
            t_op[0] = mem_sel ? (mem_wr ? 2 : 1) : 0;
            t_ad[0] = mem_addr;
            for (int k = 1; k < LAT; k++) begin
                t_op[k] = s_op[k-1];
                t_ad[k] = s_ad[k-1];
            end
            for (int k = 0; k < LAT; k++) begin
                s_op[k] <= t_op[k];
                s_ad[k] <= t_ad[k];
            end
            if (t_op[LAT-1] == 1) begin
                sram_drv <= 1'b1;
                sram_dq  <= (s_op[LAT-1] == 2 && s_ad[LAT-1] == t_ad[LAT-1]) ?
                            mem_dq_out : smem[t_ad[LAT-1]];
            end else begin
                sram_drv <= 1'b0;
            end
        end
    end

    // ---------------- scoreboard state ----------------
    int            checks = 0;
    int            errors = 0;
    int            cmd_op_l [QN];
    logic [AW-1:0] cmd_ad_l [QN];
    logic [DW-1:0] cmd_dat_l [QN];
    int            cmd_tag [QN];
    int            cw = 0, cr = 0;
    logic [DW-1:0] exp_rd [QN];
    int            ew = 0, er = 0;
    int            hist_op [4];
    logic [DW-1:0] hist_dat [4];
    logic [DW-1:0] ref_mem [DEPTH];
    int            rem = 0;
    logic          p_sel, p_wr, p_oe;
    logic [AW-1:0] p_addr;
    logic [DW-1:0] p_out;
    logic [15:0]   lfsr = 16'hACE1;

    function automatic string tagname(input int c);
        case (c)
            6:       return "R6";
            7:       return "R7";
            default: return "R2";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic save_prev();
        p_sel = mem_sel; p_wr = mem_wr; p_addr = mem_addr; p_oe = mem_dq_oe; p_out = mem_dq_out;
    endtask

    task automatic observe(input bit e);
        int cur;
        if (e) begin
            for (int k = 3; k > 0; k--) begin
                hist_op[k]  = hist_op[k-1];
                hist_dat[k] = hist_dat[k-1];
            end
            cur = mem_sel ? (mem_wr ? 2 : 1) : 0;
            hist_op[0]  = cur;
            hist_dat[0] = '0;
            if (cur != 0) begin
                if (cr == cw) begin
                    chk(1'b0, "R5", "command with nothing pending", cur, 0);
                end else begin
                    chk(cur == cmd_op_l[cr], tagname(cmd_tag[cr]), "command type", cur, cmd_op_l[cr]);
                    chk(mem_addr == cmd_ad_l[cr], tagname(cmd_tag[cr]), "command address",
                        mem_addr, cmd_ad_l[cr]);
                    hist_dat[0] = cmd_dat_l[cr];
                    cr++;
                end
            end else begin
                chk(cr == cw, "R5", "idle slot while commands pending", cw - cr, 0);
            end
            // R3 late-write slot
            chk(mem_dq_oe == (hist_op[LAT] == 2), "R3", "bus enable in data slot",
                mem_dq_oe, hist_op[LAT] == 2);
            if (hist_op[LAT] == 2)
                chk(mem_dq_out == hist_dat[LAT], "R3", "write data on bus", mem_dq_out, hist_dat[LAT]);
            // R4 read return
            chk(rd_valid == (hist_op[LAT+1] == 1), "R4", "read strobe timing",
                rd_valid, hist_op[LAT+1] == 1);
            if (rd_valid) begin
                if (er < ew) begin
                    chk(rd_data == exp_rd[er], "R4", "read data in issue order", rd_data, exp_rd[er]);
                    er++;
                end else begin
                    chk(1'b0, "R4", "read strobe with nothing outstanding", 1, 0);
                end
            end
        end else begin
            // R8 stall holds memory side
            chk(mem_sel == p_sel && mem_wr == p_wr && mem_addr == p_addr, "R8",
                "command pins moved on stall", mem_addr, p_addr);
            chk(mem_dq_oe == p_oe && mem_dq_out == p_out, "R8", "bus drive moved on stall",
                mem_dq_oe, p_oe);
            chk(rd_valid == 1'b0, "R8", "read strobe on stall", rd_valid, 0);
        end
        chk(!(mem_dq_oe && sram_drv), "R5", "bus contention", 1, 0);
        save_prev();
    endtask

    task automatic step(input bit v, input bit w, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input logic [BW-1:0] b, input bit e,
                        output bit acc);
        logic [AW-1:0] ad;
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_burst = b; clk_en = e;
        #1;
        chk(req_ready == (e && rem == 0), e ? "R6" : "R8", "ready level", req_ready, e && rem == 0);
        acc = v && req_ready;
        if (acc) begin
            if (w) begin
                cmd_op_l[cw] = 2; cmd_ad_l[cw] = a; cmd_dat_l[cw] = d; cmd_tag[cw] = 2; cw++;
                ref_mem[a] = d;
            end else begin
                for (int k = 0; k <= int'(b); k++) begin
                    ad = a + AW'(k);
                    cmd_op_l[cw] = 1; cmd_ad_l[cw] = ad; cmd_dat_l[cw] = '0;
                    cmd_tag[cw] = (k == 0) ? 2 : ((int'(a) + k >= DEPTH) ? 7 : 6);
                    cw++;
                    exp_rd[ew] = ref_mem[ad]; ew++;
                end
            end
        end
        if (e) begin
            if (rem > 0) rem--;
            else if (acc && !w) rem = int'(b);
        end
        @(negedge clk);
        observe(e);
    endtask

    task automatic issue(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [BW-1:0] b);
        bit acc;
        acc = 1'b0;
        while (!acc) step(1'b1, w, a, d, b, 1'b1, acc);
    endtask

    task automatic idle(input int n);
        bit acc;
        repeat (n) step(1'b0, 1'b0, '0, '0, '0, 1'b1, acc);
    endtask

    task automatic do_reset();
        rst = 1'b1; req_valid = 1'b0; clk_en = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        cr = cw; er = ew; rem = 0;
        for (int k = 0; k < 4; k++) begin hist_op[k] = 0; hist_dat[k] = '0; end
        chk(mem_sel == 1'b0, "R1", "command after reset", mem_sel, 0);
        chk(mem_dq_oe == 1'b0, "R1", "bus enable after reset", mem_dq_oe, 0);
        chk(rd_valid == 1'b0, "R1", "read strobe after reset", rd_valid, 0);
        #1;
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        save_prev();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        chk(1'b0, "R5", "watchdog expired", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        bit acc;
        for (int a = 0; a < DEPTH; a++) ref_mem[a] = '0;
        do_reset();

        // R5: fill every word back to back, then read all back to back
        for (int a = 0; a < DEPTH; a++) issue(1'b1, AW'(a), DW'(a * 257) ^ 16'h5A5A, '0);
        for (int a = 0; a < DEPTH; a++) issue(1'b0, AW'(a), '0, '0);

        // R5: write then read of the same word on adjacent cycles
        for (int a = 0; a < DEPTH; a++) begin
            issue(1'b1, AW'(a), ~DW'(a * 31), '0);
            issue(1'b0, AW'(a), '0, '0);
        end

        // R5/R6: write, write, read, write, read, burst read
        issue(1'b1, 6'd5, 16'h1111, '0);
        issue(1'b1, 6'd6, 16'h2222, '0);
        issue(1'b0, 6'd5, '0, '0);
        issue(1'b1, 6'd7, 16'h3333, '0);
        issue(1'b0, 6'd6, '0, '0);
        issue(1'b0, 6'd4, '0, 2'd3);
        issue(1'b1, 6'd8, 16'h4444, '0);

        // R6/R7: every burst length at several starts, including the wrap
        for (int b = 0; b < 4; b++) begin
            issue(1'b0, 6'd0,  '0, BW'(b));
            issue(1'b0, 6'd17, '0, BW'(b));
            issue(1'b0, 6'd62, '0, BW'(b));
            issue(1'b0, 6'd63, '0, BW'(b));
            issue(1'b1, 6'd63, DW'(16'hB000 + b), '0);
        end
        idle(6);

        // R8 and mixed traffic with stalls
        for (int i = 0; i < 900; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[2] | lfsr[3], lfsr[4], lfsr[10:5], lfsr ^ 16'h3C3C, lfsr[12:11],
                 lfsr[1:0] != 2'b00, acc);
        end
        idle(8);

        // R1: reset with a burst of reads still in flight
        issue(1'b0, 6'd60, '0, 2'd3);
        idle(1);
        do_reset();
        for (int a = 0; a < 8; a++) issue(1'b0, AW'(a * 9), '0, '0);

        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(1'b1, lfsr[4], lfsr[10:5], lfsr, lfsr[12:11], lfsr[1:0] != 2'b01, acc);
        end
        idle(8);

        // R3: memory contents match every accepted write
        chk(model_err == 0, "R3", "memory saw write slot without drive", model_err, 0);
        for (int a = 0; a < DEPTH; a++)
            chk(smem[a] == ref_mem[a], "R3", "final memory word", smem[a], ref_mem[a]);
        chk(er == ew, "R4", "reads returned", er, ew);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule